// File: doc/BRIEF.md
# Configurable Full-Duplex UART with Selectable Parity

This block is a full-duplex asynchronous serial port. The transmitter and the receiver share one mode register. It holds four fields: a 2-bit parity mode, a character-length bit, a transmit stop-length bit and an error-routing bit. A 16x baud tick comes from outside the block and drives both directions. Separate enable inputs turn the transmitter and the receiver on and off.

Software writes a byte into the transmitter when `tx_busy` is low. Characters it receives land in a holding register. A 3-bit status word sits beside it with parity, framing and overrun flags, and reading the holding register clears that word. Two one-cycle interrupt pulses report what happened: `irq_rx` for a finished character, and `irq_err` for an erroneous one when errors are routed apart.

Top module: `sio_frame_uart`

## Requirements
- R1: A transmit frame is a 0 start bit, then the data bits least significant first, then an optional parity bit, then stop bits at 1. `cfg_parity` 00 sends no parity bit, 01 always sends 0, 10 sends odd parity and 11 sends even parity.
- R2: `cfg_len8` 0 gives 7 data bits and 1 gives 8, in both directions. A 7-bit received character reads with `rx_data[7]` = 0.
- R3: `cfg_stop2` 1 sends two stop bits and 0 sends one. `tx_busy` stays high until the last stop bit has finished.
- R4: The receiver checks exactly one stop bit, whatever `cfg_stop2` holds. A start bit that follows a single stop bit is received as a new character.
- R5: In zero-parity mode (01) the receiver takes the parity position without checking it, so the parity flag `rx_status[0]` never sets.
- R6: In odd (10) and even (11) mode a received parity bit of the wrong sense sets `rx_status[0]`.
- R7: A stop bit sampled at 0 sets the framing flag `rx_status[1]`.
- R8: A character that completes while the previous one is still unread sets the overrun flag `rx_status[2]` and leaves `rx_data` unchanged.
- R9: With `cfg_errsep` 0, every received character, erroneous or not, pulses `irq_rx`. With `cfg_errsep` 1, an erroneous character pulses only `irq_err`. The two pulses never occur together.
- R10: Writes to the parity and length fields take effect only while both enables are low. A write to the stop field needs `tx_en` low, and a write to the error-routing field needs `rx_en` low. A blocked write leaves the field as it was.
- R11: `rx_rd` clears all three status flags. A read in the same cycle as a character completes consumes the old character, so the new one is stored without overrun.
- R12: With `tx_en` low, `txd` is 1 and `tx_busy` is 0, and any frame in progress is dropped. A `tx_wr` while the transmitter is busy or disabled is ignored.
- R13: After reset, `txd` is 1, `tx_busy` is 0, `rx_data` and `rx_status` are 0, and no interrupt is pending. The mode fields reset to no parity, 7 bits, one stop bit and shared interrupt routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_stop2 | input | 1 | 1 = two transmit stop bits |
| cfg_errsep | input | 1 | 1 = errors go to `irq_err` |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | 8 | Transmit character |
| tx_busy | output | 1 | Transmitter is sending a frame |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 8 | Last received character |
| rx_status | output | 3 | {overrun, framing, parity} flags |
| irq_rx | output | 1 | Character-complete pulse |
| irq_err | output | 1 | Receive-error pulse |

## Verification
A software read of the receive register and the completion of a new character can land in the same clock cycle, and the order between them decides whether an overrun is reported. The bench first sends one character at a fixed phase of the baud tick and records the exact cycle in which completion is registered. It then leaves that character unread and sends a second one at the same phase, with `rx_rd` pulsed in the recorded cycle. The pass condition is that the second character is stored and all status flags read zero.

// File: rtl/sio_frame_uart.sv
module sio_frame_uart #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       cfg_we,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_len8,
  input  logic       cfg_stop2,
  input  logic       cfg_errsep,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_busy,
  output logic       txd,
  input  logic       rxd,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic [2:0] rx_status,
  output logic       irq_rx,
  output logic       irq_err
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  logic [1:0] par_q;
  logic       len8_q, stop2_q, errsep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= 2'b00;
      len8_q   <= 1'b0;
      stop2_q  <= 1'b0;
      errsep_q <= 1'b0;
    end else if (cfg_we) begin
      if (!tx_en && !rx_en) begin
        par_q  <= cfg_parity;
        len8_q <= cfg_len8;
      end
      if (!tx_en) stop2_q <= cfg_stop2;
      if (!rx_en) errsep_q <= cfg_errsep;
    end
  end

  // transmitter
  logic [7:0]    tx_dm;
  logic          tx_pbit;
  logic [11:0]   tx_frame, tx_sh;
  logic [3:0]    tx_nbits, tx_left;
  logic [CW-1:0] tx_cnt;

  assign tx_dm = len8_q ? tx_data : {1'b0, tx_data[6:0]};

  always_comb begin
    case (par_q)
      2'b10:   tx_pbit = ~^tx_dm;
      2'b11:   tx_pbit = ^tx_dm;
      default: tx_pbit = 1'b0;
    endcase
  end

  always_comb begin
    tx_frame = '1;
    tx_frame[0] = 1'b0;
    if (len8_q) begin
      tx_frame[8:1] = tx_data;
      if (par_q != 2'b00) tx_frame[9] = tx_pbit;
    end else begin
      tx_frame[7:1] = tx_data[6:0];
      if (par_q != 2'b00) tx_frame[8] = tx_pbit;
    end
  end

  assign tx_nbits = 4'd9 + {3'b0, len8_q} + {3'b0, |par_q} + {3'b0, stop2_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else if (!tx_en) begin
      tx_busy <= 1'b0;
    end else if (!tx_busy) begin
      if (tx_wr) begin
        tx_sh   <= tx_frame;
        tx_left <= tx_nbits;
        tx_cnt  <= '0;
        tx_busy <= 1'b1;
      end
    end else if (baud_tick) begin
      if (tx_cnt == LAST) begin
        tx_cnt  <= '0;
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 4'd1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  assign txd = ~tx_busy | tx_sh[0];

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;
  rx_state_t     rx_st;
  logic [1:0]    rx_sy;
  logic          rxs;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_idx, rx_nd;
  logic [8:0]    rx_bits;
  logic          rx_done, rx_full, pe_new, fe_new, pin;
  logic [7:0]    rx_new;
  logic          pe_q, fe_q, ovr_q;

  assign rxs     = rx_sy[1];
  assign rx_nd   = 4'd7 + {3'b0, len8_q} + {3'b0, |par_q};
  assign rx_done = rx_en && baud_tick && rx_st == RX_STOP && rx_cnt == LAST;
  assign rx_new  = len8_q ? rx_bits[7:0] : {1'b0, rx_bits[6:0]};
  assign pin     = len8_q ? rx_bits[8] : rx_bits[7];
  assign pe_new  = par_q[1] && (pin != (par_q[0] ? ^rx_new : ~^rx_new));
  assign fe_new  = ~rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sy <= 2'b11;
    else        rx_sy <= {rx_sy[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st   <= RX_IDLE;
      rx_cnt  <= '0;
      rx_idx  <= '0;
      rx_bits <= '0;
    end else if (!rx_en) begin
      rx_st <= RX_IDLE;
    end else if (baud_tick) begin
      case (rx_st)
        RX_IDLE: if (!rxs) begin
          rx_st  <= RX_START;
          rx_cnt <= '0;
        end
        RX_START: if (rx_cnt == MID) begin
          rx_cnt <= '0;
          rx_idx <= '0;
          rx_st  <= rxs ? RX_IDLE : RX_BITS;
        end else rx_cnt <= rx_cnt + 1'b1;
        RX_BITS: if (rx_cnt == LAST) begin
          rx_cnt <= '0;
          rx_bits[rx_idx] <= rxs;
          rx_idx <= rx_idx + 4'd1;
          if (rx_idx == rx_nd - 4'd1) rx_st <= RX_STOP;
        end else rx_cnt <= rx_cnt + 1'b1;
        RX_STOP: if (rx_cnt == LAST) rx_st <= RX_IDLE;
                 else rx_cnt <= rx_cnt + 1'b1;
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      ovr_q   <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
      if (rx_rd) begin
        pe_q    <= 1'b0;
        fe_q    <= 1'b0;
        ovr_q   <= 1'b0;
        rx_full <= 1'b0;
      end
      if (rx_done) begin
        if (rx_full && !rx_rd) begin
          ovr_q <= 1'b1;
          if (errsep_q) irq_err <= 1'b1;
          else          irq_rx  <= 1'b1;
        end else begin
          rx_data <= rx_new;
          pe_q    <= pe_new;
          fe_q    <= fe_new;
          rx_full <= 1'b1;
          if (errsep_q && (pe_new || fe_new)) irq_err <= 1'b1;
          else                                irq_rx  <= 1'b1;
        end
      end
    end
  end

  assign rx_status = {ovr_q, fe_q, pe_q};

  AST_TX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (txd && !tx_busy)); // R12
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || rx_en) |=> ($stable(par_q) && $stable(len8_q))); // R10
  AST_PE_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_status[0]) |-> par_q[1]); // R5
  AST_ERR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> errsep_q); // R9
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_err)); // R9
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_status[2]) |-> $stable(rx_data)); // R8
endmodule

// File: tb/sio_frame_uart_test.sv
module sio_frame_uart_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, rx_en = 0, cfg_we = 0, cfg_len8 = 0, cfg_stop2 = 0, cfg_errsep = 0;
  logic [1:0] cfg_parity = 0;
  logic tx_wr = 0, rx_rd = 0, rx_drv = 1, loopb = 0;
  logic [7:0] tx_data = 0;
  logic tx_busy, txd, irq_rx, irq_err, rxd, baud_tick;
  logic [7:0] rx_data;
  logic [2:0] rx_status;
  int cyc = 0, n_rx = 0, n_err = 0, tests = 0, fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign baud_tick = cyc[0];
  assign rxd = loopb ? txd : rx_drv;
  always @(negedge clk) begin
    if (irq_rx)  n_rx++;
    if (irq_err) n_err++;
  end

  sio_frame_uart uut (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .rx_en(rx_en), .cfg_we(cfg_we), .cfg_parity(cfg_parity), .cfg_len8(cfg_len8),
    .cfg_stop2(cfg_stop2), .cfg_errsep(cfg_errsep), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_status(rx_status), .irq_rx(irq_rx), .irq_err(irq_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] tx_model(logic [1:0] p, logic l8, logic s2, logic [7:0] d);
    logic [11:0] f = '1;
    logic [7:0] m = l8 ? d : {1'b0, d[6:0]};
    int n = 1;
    f[0] = 1'b0;
    for (int i = 0; i < (l8 ? 8 : 7); i++) begin f[n] = m[i]; n++; end
    if (p != 2'b00) begin
      f[n] = (p == 2'b01) ? 1'b0 : (p == 2'b10) ? ~^m : ^m;
      n++;
    end
    n += s2 ? 2 : 1;
    return {4'(n), f};
  endfunction

  function automatic logic [27:0] rx_frame(logic l8, logic hp, logic pb, logic sv, logic [7:0] d);
    logic [23:0] f = '1;
    int n = 1;
    f[0] = 1'b0;
    for (int i = 0; i < (l8 ? 8 : 7); i++) begin f[n] = d[i]; n++; end
    if (hp) begin f[n] = pb; n++; end
    f[n] = sv; n++;
    return {4'(n), f};
  endfunction

  task automatic set_cfg(input logic [1:0] p, input logic l8, input logic s2, input logic es);
    cfg_parity = p; cfg_len8 = l8; cfg_stop2 = s2; cfg_errsep = es; cfg_we = 1;
    @(negedge clk); cfg_we = 0; @(negedge clk);
  endtask

  task automatic do_read;
    rx_rd = 1; @(negedge clk); rx_rd = 0; @(negedge clk);
  endtask

  task automatic align;
    @(negedge clk);
    while (cyc[0] !== 1'b0) @(negedge clk);
  endtask

  task automatic rx_send(input logic [23:0] f, input int n, input int rd_at, output int irq_at);
    irq_at = -1;
    align();
    for (int k = 0; k < n * 32 + 64; k++) begin
      rx_drv = (k < n * 32) ? f[k / 32] : 1'b1;
      rx_rd = (k == rd_at);
      @(negedge clk);
      if (irq_at < 0 && (irq_rx || irq_err)) irq_at = k;
    end
    rx_rd = 0;
  endtask

  task automatic tx_cap(input int n, input logic s2, input string tag, output logic [11:0] bits);
    int w = 0;
    bits = '1;
    while (txd !== 1'b0 && w < 400) begin @(negedge clk); w++; end
    repeat (16) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i < n - 1) repeat (32) @(negedge clk);
    end
    if (s2) chk({tag, " R3 busy in 2nd stop"}, tx_busy, 1'b1);
    repeat (24) @(negedge clk);
    chk({tag, " R3 busy after frame"}, tx_busy, 1'b0);
  endtask

  task automatic tx_write(input logic [7:0] d);
    tx_data = d; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask

  localparam logic [11:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b0, 8'h55}, {2'b01, 1'b1, 1'b0, 8'hA5},
    {2'b10, 1'b1, 1'b1, 8'h3C}, {2'b11, 1'b1, 1'b0, 8'h3C},
    {2'b11, 1'b0, 1'b1, 8'hC3}, {2'b10, 1'b1, 1'b0, 8'h00},
    {2'b11, 1'b1, 1'b1, 8'hFF}, {2'b00, 1'b1, 1'b1, 8'h80}};

  initial begin
    #(8 * 190000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] m;
    logic [27:0] r, r2;
    logic [11:0] cap;
    int ia, ib, rx0, er0;
    repeat (3) @(negedge clk);
    chk("R13 txd reset", txd, 1'b1);
    chk("R13 busy reset", tx_busy, 1'b0);
    chk("R13 status reset", rx_status, 3'b000);
    chk("R13 data reset", rx_data, 8'h00);
    chk("R13 irq reset", {irq_rx, irq_err}, 2'b00);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[v]) begin
      tx_en = 0; rx_en = 0; loopb = 1;
      @(negedge clk);
      set_cfg(VEC[v][11:10], VEC[v][9], VEC[v][8], 1'b0);
      rx_en = 1; tx_en = 1;
      do_read();
      rx0 = n_rx;
      m = tx_model(VEC[v][11:10], VEC[v][9], VEC[v][8], VEC[v][7:0]);
      tx_write(VEC[v][7:0]);
      tx_cap(int'(m[15:12]), VEC[v][8], $sformatf("vec%0d", v), cap);
      chk($sformatf("R1 R2 vec%0d tx frame", v), cap, m[11:0]);
      repeat (40) @(negedge clk);
      chk($sformatf("R2 vec%0d rx data", v), rx_data, VEC[v][9] ? VEC[v][7:0] : {1'b0, VEC[v][6:0]});
      chk($sformatf("R6 vec%0d rx status clean", v), rx_status, 3'b000);
      chk($sformatf("R9 vec%0d irq_rx", v), n_rx - rx0, 1);
    end
    tx_en = 0; rx_en = 0; loopb = 0;
    @(negedge clk);

    // zero parity: parity position 1 is not checked
    set_cfg(2'b01, 1'b1, 1'b0, 1'b1);
    rx_en = 1; do_read(); rx0 = n_rx; er0 = n_err;
    r = rx_frame(1'b1, 1'b1, 1'b1, 1'b1, 8'h12);
    rx_send(r[23:0], int'(r[27:24]), -1, ia);
    chk("R5 zero parity data", rx_data, 8'h12);
    chk("R5 zero parity no flag", rx_status, 3'b000);
    chk("R5 zero parity no err irq", n_err - er0, 0);

    // odd parity mismatch, shared irq
    rx_en = 0; @(negedge clk);
    set_cfg(2'b10, 1'b1, 1'b0, 1'b0);
    rx_en = 1; do_read(); rx0 = n_rx; er0 = n_err;
    r = rx_frame(1'b1, 1'b1, 1'b1, 1'b1, 8'h01);
    rx_send(r[23:0], int'(r[27:24]), -1, ia);
    chk("R6 odd mismatch flag", rx_status, 3'b001);
    chk("R9 shared irq_rx", n_rx - rx0, 1);
    chk("R9 shared no irq_err", n_err - er0, 0);
    do_read();
    chk("R11 read clears", rx_status, 3'b000);

    // even parity mismatch, separate irq
    rx_en = 0; @(negedge clk);
    set_cfg(2'b11, 1'b1, 1'b0, 1'b1);
    rx_en = 1; rx0 = n_rx; er0 = n_err;
    r = rx_frame(1'b1, 1'b1, 1'b0, 1'b1, 8'h01);
    rx_send(r[23:0], int'(r[27:24]), -1, ia);
    chk("R6 even mismatch flag", rx_status, 3'b001);
    chk("R9 separate irq_err", n_err - er0, 1);
    chk("R9 separate no irq_rx", n_rx - rx0, 0);
    do_read();

    // framing error
    rx_en = 0; @(negedge clk);
    set_cfg(2'b00, 1'b1, 1'b0, 1'b1);
    rx_en = 1; er0 = n_err;
    r = rx_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
    rx_send(r[23:0], int'(r[27:24]), -1, ia);
    chk("R7 framing flag", rx_status, 3'b010);
    chk("R7 framing irq_err", n_err - er0, 1);
    rx_en = 0; @(negedge clk); rx_en = 1; do_read();

    // back-to-back frames with one stop bit: overrun keeps first
    rx_en = 0; @(negedge clk);
    set_cfg(2'b00, 1'b1, 1'b1, 1'b0);
    rx_en = 1; do_read(); rx0 = n_rx;
    r  = rx_frame(1'b1, 1'b0, 1'b0, 1'b1, 8'h11);
    r2 = rx_frame(1'b1, 1'b0, 1'b0, 1'b1, 8'h22);
    rx_send({r2[3:0], r[9:0]} | 24'hFFC000, 20, -1, ia);
    chk("R8 overrun keeps data", rx_data, 8'h11);
    chk("R4 R8 overrun flag", rx_status, 3'b100);
    chk("R4 two completions", n_rx - rx0, 2);
    do_read();

    // read in the completion cycle
    r = rx_frame(1'b1, 1'b0, 1'b0, 1'b1, 8'h33);
    rx_send(r[23:0], int'(r[27:24]), -1, ia);
    chk("R11 first char", rx_data, 8'h33);
    r = rx_frame(1'b1, 1'b0, 1'b0, 1'b1, 8'h44);
    rx_send(r[23:0], int'(r[27:24]), ia, ib);
    chk("R11 same-cycle read data", rx_data, 8'h44);
    chk("R11 same-cycle read no overrun", rx_status, 3'b000);
    do_read();

    // config lock while tx enabled
    rx_en = 0; tx_en = 0; @(negedge clk);
    set_cfg(2'b00, 1'b1, 1'b0, 1'b0);
    tx_en = 1; @(negedge clk);
    set_cfg(2'b11, 1'b0, 1'b1, 1'b1);
    m = tx_model(2'b00, 1'b1, 1'b0, 8'hA5);
    tx_write(8'hA5);
    tx_cap(int'(m[15:12]), 1'b0, "lock", cap);
    chk("R10 blocked parity/len/stop", cap, m[11:0]);
    tx_en = 0; rx_en = 1; er0 = n_err;
    r = rx_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
    rx_send(r[23:0], int'(r[27:24]), -1, ia);
    chk("R10 errsep accepted", n_err - er0, 1);
    rx_en = 0; @(negedge clk);

    // transmit disable and ignored writes
    tx_write(8'h5A);
    chk("R12 write while disabled", {tx_busy, txd}, 2'b01);
    tx_en = 1; @(negedge clk);
    tx_write(8'hF0);
    repeat (100) @(negedge clk);
    chk("R12 busy mid frame", tx_busy, 1'b1);
    tx_en = 0; @(negedge clk);
    chk("R12 abort", {tx_busy, txd}, 2'b01);
    tx_en = 1; @(negedge clk);
    m = tx_model(2'b00, 1'b1, 1'b0, 8'h81);
    tx_write(8'h81);
    tx_write(8'h7E);
    tx_cap(int'(m[15:12]), 1'b0, "busy-wr", cap);
    chk("R12 write while busy ignored", cap, m[11:0]);
    repeat (40) @(negedge clk);
    chk("R12 no second frame", {tx_busy, txd}, 2'b01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule